// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter in a small microcontroller. Software writes one control word that holds a power enable, a conversion-clock choice and a one-bit channel number. If the enable is set, that write also starts a conversion. During a conversion the sequencer first holds the sample switch closed. It then runs a binary search on a trial code that it drives to the converter's DAC, reading a single comparator bit at each step. When the fixed conversion length has elapsed, it raises a completion flag and loads the result register.

The conversion clock can be the bus clock or a separate clock input that has no phase relationship to the bus clock. With the separate clock, a copy of the sequencer runs in that clock domain. A start toggle carries the request into that domain, and a done toggle carries completion back to the bus domain. Each toggle passes through two synchronizing flops. The bus side reads the result only after the done toggle arrives, and the result is held steady from that point. A stop request, held as a level, abandons any conversion and raises no flag. The sequencer has no wait input and runs through wait modes unchanged.

Top module: `sar_adc_seq`

## Requirements
- R1: While reset is asserted and right after it, en_o, clksel_o, chan_o, done_o, sample_o are 0 and result_o is 0.
- R2: A cycle with ctl_wr high loads en_o, clksel_o and chan_o from wr_en, wr_clksel and wr_chan and clears done_o at that clock edge. When wr_en is 1 and stop_req is 0, the write starts a conversion.
- R3: With wr_clksel 0 (bus clock), done_o rises at the 32nd rising clk_bus edge after the edge that took the write.
- R4: The trial code on dac_o starts at 8'h80. Each step tests one bit, from the MSB down to the LSB. A bit stays set when cmp_in is 1 (input at or above the trial code) and clears otherwise. So for a comparator that reports input >= dac_o, result_o equals the input value.
- R5: sample_o is high for the first two conversion cycles and low afterwards. In bus-clock mode, dac_o is 8'h80 in the cycle after the second edge following the write.
- R6: With wr_clksel 1, the conversion runs on clk_alt. done_o and result_o appear in the bus domain after the synchronizing handshake, and result_o follows R4.
- R7: While stop_req is held high, any conversion in progress is dropped: done_o stays 0 and result_o keeps its value. A later write starts normally.
- R8: A write with wr_en 0 starts nothing, and done_o stays 0.
- R9: result_o changes only in the cycle in which done_o rises.
- R10: chan_o presents the written one-bit channel number to the analog multiplexer, 0 for the first input and 1 for the second.
- R11: A new write during a conversion restarts it. done_o then rises 32 bus edges after the later write, with the later input's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_alt | input | 1 | Alternate conversion clock, asynchronous to clk_bus |
| ctl_wr | input | 1 | Control word write strobe |
| wr_en | input | 1 | Converter enable to write |
| wr_clksel | input | 1 | Clock choice to write: 0 bus, 1 alternate |
| wr_chan | input | 1 | Channel number to write |
| stop_req | input | 1 | Stop-mode request, level |
| cmp_in | input | 1 | Comparator output: 1 when input >= dac_o |
| en_o | output | 1 | Enable bit |
| clksel_o | output | 1 | Clock choice bit |
| chan_o | output | 1 | Channel select to the analog multiplexer |
| done_o | output | 1 | Conversion complete flag |
| result_o | output | 8 | Result register |
| sample_o | output | 1 | Sample switch control |
| dac_o | output | 8 | Trial code for the DAC |

## Verification
Input values 8'h00 and 8'hFF push every comparison one way, so they expose a reversed keep-or-clear decision. 8'hA5 and 8'h5A set alternating bits, which exposes a wrong bit order or an off-by-one in the step index. The same kinds of value are converted in both clock modes, with both channel numbers, so a result that is right on the bus clock but corrupted across the handshake shows up. Writes with the enable clear, held stop requests in each mode, and a restart in the middle of a conversion separate abort and restart behaviour from normal completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W_DEF    = 8;
  localparam int CONV_CYC_DEF = 32;
  localparam int SAMP_CYC_DEF = 2;

  typedef struct packed {
    logic en;
    logic clksel;
    logic chan;
  } adc_ctl_t;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/adc_cdc_sync.sv
module adc_cdc_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic lvl_o,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES_W    = adc_seq_pkg::RES_W_DEF,
  parameter int CONV_CYC = adc_seq_pkg::CONV_CYC_DEF,
  parameter int SAMP_CYC = adc_seq_pkg::SAMP_CYC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             cmp_in,
  output logic             busy_o,
  output logic             fin_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] sar_o,
  output logic             done_tgl_o
);
  localparam int CNT_W   = $clog2(CONV_CYC);
  localparam int RES_END = SAMP_CYC + RES_W;
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(CONV_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_RES0  = CNT_W'(SAMP_CYC);
  localparam logic [CNT_W-1:0] CNT_REND  = CNT_W'(RES_END);
  localparam logic [CNT_W-1:0] CNT_TOPIX = CNT_W'(RES_END - 1);

  logic             busy_q, busy_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [RES_W-1:0] sar_q, sar_n;
  logic             tgl_q, tgl_n;

  logic             in_res;
  logic             fin;
  logic [CNT_W-1:0] bit_idx;
  logic [RES_W-1:0] trial;

  always_comb begin
    in_res  = busy_q && (cnt_q >= CNT_RES0) && (cnt_q < CNT_REND);
    fin     = busy_q && (cnt_q == CNT_LAST);
    bit_idx = CNT_TOPIX - cnt_q;
    trial   = in_res ? (sar_q | (RES_W'(1) << bit_idx)) : sar_q;
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    sar_n  = sar_q;
    tgl_n  = tgl_q;
    if (start) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      sar_n  = '0;
    end else if (abort) begin
      busy_n = 1'b0;
      cnt_n  = '0;
    end else if (busy_q) begin
      cnt_n = cnt_q + CNT_W'(1);
      if (in_res) begin
        sar_n = cmp_in ? trial : sar_q;
      end
      if (fin) begin
        busy_n = 1'b0;
        cnt_n  = '0;
        tgl_n  = ~tgl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sar_q  <= '0;
      tgl_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      sar_q  <= sar_n;
      tgl_q  <= tgl_n;
    end
  end

  assign busy_o     = busy_q;
  assign fin_o      = fin;
  assign sample_o   = busy_q && (cnt_q < CNT_RES0);
  assign dac_o      = trial;
  assign sar_o      = sar_q;
  assign done_tgl_o = tgl_q;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && cnt_q == '0 && sar_q == '0)); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !busy_q); // R7
  AST_SAR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !in_res && !start && !abort) |=> $stable(sar_q)); // R4
  AST_FIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> (!busy_q && tgl_q != $past(tgl_q))); // R3
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int RES_W    = adc_seq_pkg::RES_W_DEF,
  parameter int CONV_CYC = adc_seq_pkg::CONV_CYC_DEF,
  parameter int SAMP_CYC = adc_seq_pkg::SAMP_CYC_DEF
) (
  input  logic             clk_bus,
  input  logic             rst_n,
  input  logic             clk_alt,
  input  logic             ctl_wr,
  input  logic             wr_en,
  input  logic             wr_clksel,
  input  logic             wr_chan,
  input  logic             stop_req,
  input  logic             cmp_in,
  output logic             en_o,
  output logic             clksel_o,
  output logic             chan_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o
);
  import adc_seq_pkg::*;

  logic rst_b_n, rst_a_n;

  adc_rst_sync u_rst_b (.clk(clk_bus), .arst_n(rst_n), .rst_n_o(rst_b_n));
  adc_rst_sync u_rst_a (.clk(clk_alt), .arst_n(rst_n), .rst_n_o(rst_a_n));

  adc_ctl_t         ctl_q, ctl_n;
  logic             cc_q, cc_n;
  logic             pend_q, pend_n;
  logic [RES_W-1:0] res_q, res_n;
  logic             go_q, go_n;

  logic start_b, abort_b, start_a_req;

  always_comb begin
    start_b     = ctl_wr && wr_en && !wr_clksel && !stop_req;
    start_a_req = ctl_wr && wr_en &&  wr_clksel && !stop_req;
    abort_b     = stop_req || ctl_wr;
  end

  // Bus-clock converter
  logic             busy_b, fin_b, samp_b, tgl_b;
  logic [RES_W-1:0] dac_b, sar_b;

  sar_core #(.RES_W(RES_W), .CONV_CYC(CONV_CYC), .SAMP_CYC(SAMP_CYC)) u_core_b (
    .clk(clk_bus), .rst_n(rst_b_n), .start(start_b), .abort(abort_b),
    .cmp_in(cmp_in), .busy_o(busy_b), .fin_o(fin_b), .sample_o(samp_b),
    .dac_o(dac_b), .sar_o(sar_b), .done_tgl_o(tgl_b)
  );

  // Alternate-clock converter and its crossings
  logic go_lvl_a, go_a, stop_a, stop_edge_a;
  logic             busy_a, fin_a, samp_a, tgl_a;
  logic [RES_W-1:0] dac_a, sar_a;
  logic done_lvl_b, cap_a;

  adc_cdc_sync u_go_sync (
    .clk(clk_alt), .rst_n(rst_a_n), .d_in(go_q), .lvl_o(go_lvl_a), .edge_o(go_a)
  );
  adc_cdc_sync u_stop_sync (
    .clk(clk_alt), .rst_n(rst_a_n), .d_in(stop_req), .lvl_o(stop_a), .edge_o(stop_edge_a)
  );

  sar_core #(.RES_W(RES_W), .CONV_CYC(CONV_CYC), .SAMP_CYC(SAMP_CYC)) u_core_a (
    .clk(clk_alt), .rst_n(rst_a_n), .start(go_a), .abort(stop_a),
    .cmp_in(cmp_in), .busy_o(busy_a), .fin_o(fin_a), .sample_o(samp_a),
    .dac_o(dac_a), .sar_o(sar_a), .done_tgl_o(tgl_a)
  );

  adc_cdc_sync u_done_sync (
    .clk(clk_bus), .rst_n(rst_b_n), .d_in(tgl_a), .lvl_o(done_lvl_b), .edge_o(cap_a)
  );

  logic unused_tieoff;
  assign unused_tieoff = ^{busy_b, tgl_b, go_lvl_a, stop_edge_a, busy_a, fin_a, done_lvl_b};

  // Bus-side control and status registers
  always_comb begin
    ctl_n  = ctl_q;
    cc_n   = cc_q;
    pend_n = pend_q;
    res_n  = res_q;
    go_n   = go_q;
    if (ctl_wr) begin
      ctl_n.en     = wr_en;
      ctl_n.clksel = wr_clksel;
      ctl_n.chan   = wr_chan;
      cc_n         = 1'b0;
      pend_n       = wr_en && !stop_req;
      if (start_a_req) begin
        go_n = ~go_q;
      end
    end else if (stop_req) begin
      pend_n = 1'b0;
    end else if (pend_q && !ctl_q.clksel && fin_b) begin
      cc_n   = 1'b1;
      pend_n = 1'b0;
      res_n  = sar_b;
    end else if (pend_q && ctl_q.clksel && cap_a) begin
      cc_n   = 1'b1;
      pend_n = 1'b0;
      res_n  = sar_a;
    end
  end

  always_ff @(posedge clk_bus or negedge rst_b_n) begin
    if (!rst_b_n) begin
      ctl_q  <= '0;
      cc_q   <= 1'b0;
      pend_q <= 1'b0;
      res_q  <= '0;
      go_q   <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      cc_q   <= cc_n;
      pend_q <= pend_n;
      res_q  <= res_n;
      go_q   <= go_n;
    end
  end

  assign en_o     = ctl_q.en;
  assign clksel_o = ctl_q.clksel;
  assign chan_o   = ctl_q.chan;
  assign done_o   = cc_q;
  assign result_o = res_q;
  assign sample_o = ctl_q.clksel ? samp_a : samp_b;
  assign dac_o    = ctl_q.clksel ? dac_a  : dac_b;

  AST_WR_CLEARS_CC: assert property (@(posedge clk_bus) disable iff (!rst_b_n)
    ctl_wr |=> !done_o); // R2
  AST_STOP_NO_CC: assert property (@(posedge clk_bus) disable iff (!rst_b_n)
    (stop_req && !done_o) |=> !done_o); // R7
  AST_OFF_NO_CC: assert property (@(posedge clk_bus) disable iff (!rst_b_n)
    (!en_o && !done_o && !ctl_wr) |=> !done_o); // R8
  AST_RES_WITH_CC: assert property (@(posedge clk_bus) disable iff (!rst_b_n)
    !$stable(result_o) |-> $rose(done_o)); // R9
endmodule

// File: tb/tb_sar_adc_seq.sv
`timescale 1ns/1ps
module tb_sar_adc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ALT_PERIOD = 6;
  localparam int WD_CYCLES  = 150000;

  logic clk_bus = 1'b0;
  logic clk_alt = 1'b0;
  logic rst_n;
  logic ctl_wr, wr_en, wr_clksel, wr_chan, stop_req;
  logic cmp_in;
  logic en_o, clksel_o, chan_o, done_o, sample_o;
  logic [7:0] result_o, dac_o;
  logic [7:0] vin;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_bus = ~clk_bus;
  always #(ALT_PERIOD/2) clk_alt = ~clk_alt;

  assign cmp_in = (vin >= dac_o);

  sar_adc_seq dut (
    .clk_bus(clk_bus), .rst_n(rst_n), .clk_alt(clk_alt), .ctl_wr(ctl_wr),
    .wr_en(wr_en), .wr_clksel(wr_clksel), .wr_chan(wr_chan), .stop_req(stop_req),
    .cmp_in(cmp_in), .en_o(en_o), .clksel_o(clksel_o), .chan_o(chan_o),
    .done_o(done_o), .result_o(result_o), .sample_o(sample_o), .dac_o(dac_o)
  );

  // {clksel, chan, input value}
  localparam logic [9:0] VECS [0:7] = '{
    {1'b0, 1'b0, 8'h00}, {1'b0, 1'b1, 8'hFF}, {1'b0, 1'b0, 8'hA5}, {1'b0, 1'b1, 8'h5A},
    {1'b1, 1'b0, 8'h3C}, {1'b1, 1'b1, 8'h81}, {1'b1, 1'b0, 8'h01}, {1'b1, 1'b1, 8'hFE}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic en, input logic cs, input logic ch);
    @(negedge clk_bus);
    ctl_wr = 1'b1; wr_en = en; wr_clksel = cs; wr_chan = ch;
    @(negedge clk_bus);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_done(input int limit, output int n);
    n = 0;
    while (!done_o && n < limit) begin
      @(negedge clk_bus);
      n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] prev;
    ctl_wr = 0; wr_en = 0; wr_clksel = 0; wr_chan = 0; stop_req = 0; vin = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk_bus);
    // R1: state while reset is held
    check({en_o, clksel_o, chan_o, done_o, sample_o} == 5'b0 && result_o == 8'h00,
          "R1", {en_o, clksel_o, chan_o, done_o, sample_o, result_o}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk_bus);
    check({en_o, clksel_o, chan_o, done_o, sample_o} == 5'b0 && result_o == 8'h00,
          "R1", {en_o, clksel_o, chan_o, done_o, sample_o, result_o}, 0);

    // Vector walk over both clock modes and both channels
    for (int i = 0; i < 8; i++) begin
      logic cs, ch;
      logic [7:0] v;
      {cs, ch, v} = VECS[i];
      vin = v;
      prev = result_o;
      do_write(1'b1, cs, ch);
      check(en_o == 1'b1 && clksel_o == cs && done_o == 1'b0, "R2", {en_o, clksel_o, done_o}, {1'b1, cs, 1'b0});
      check(chan_o == ch, "R10", chan_o, ch);
      if (!cs) begin
        check(sample_o == 1'b1, "R5", sample_o, 1);
        n = 0;
        while (!done_o && n < 40) begin
          @(negedge clk_bus);
          n++;
          if (n == 2) begin
            check(sample_o == 1'b0 && dac_o == 8'h80, "R5", {sample_o, dac_o}, 9'h080);
          end
          if (n == 31) begin
            check(result_o == prev, "R9", result_o, prev);
          end
        end
        check(n == 32, "R3", n, 32);
        check(result_o == v, "R4", result_o, v);
      end else begin
        wait_done(300, n);
        check(done_o == 1'b1, "R6", done_o, 1);
        check(result_o == v, "R6", result_o, v);
      end
      repeat (3) @(negedge clk_bus);
    end

    // R8: write with enable clear starts nothing
    vin = 8'h77;
    do_write(1'b0, 1'b0, 1'b0);
    check(en_o == 1'b0 && done_o == 1'b0, "R2", {en_o, done_o}, 0);
    repeat (50) @(negedge clk_bus);
    check(done_o == 1'b0, "R8", done_o, 0);
    check(result_o == 8'hFE, "R8", result_o, 8'hFE);

    // R7: stop in bus-clock mode
    vin = 8'h33;
    do_write(1'b1, 1'b0, 1'b1);
    repeat (10) @(negedge clk_bus);
    stop_req = 1'b1;
    repeat (3) @(negedge clk_bus);
    stop_req = 1'b0;
    repeat (50) @(negedge clk_bus);
    check(done_o == 1'b0, "R7", done_o, 0);
    check(result_o == 8'hFE, "R7", result_o, 8'hFE);

    // R7: stop in alternate-clock mode
    do_write(1'b1, 1'b1, 1'b0);
    repeat (5) @(negedge clk_bus);
    stop_req = 1'b1;
    repeat (3) @(negedge clk_bus);
    stop_req = 1'b0;
    repeat (100) @(negedge clk_bus);
    check(done_o == 1'b0, "R7", done_o, 0);
    check(result_o == 8'hFE, "R7", result_o, 8'hFE);

    // R7: normal conversion after stop
    do_write(1'b1, 1'b0, 1'b0);
    wait_done(40, n);
    check(n == 32 && result_o == 8'h33, "R7", {n[7:0], result_o}, 16'h2033);

    // R11: restart during a conversion
    vin = 8'h44;
    do_write(1'b1, 1'b0, 1'b0);
    repeat (10) @(negedge clk_bus);
    check(done_o == 1'b0, "R11", done_o, 0);
    vin = 8'h99;
    do_write(1'b1, 1'b0, 1'b1);
    wait_done(40, n);
    check(n == 32, "R11", n, 32);
    check(result_o == 8'h99, "R11", result_o, 8'h99);

    // R2: write clears a set flag
    check(done_o == 1'b1, "R2", done_o, 1);
    do_write(1'b0, 1'b0, 1'b0);
    check(done_o == 1'b0, "R2", done_o, 0);

    // R1: reset in the middle of a conversion
    do_write(1'b1, 1'b0, 1'b1);
    repeat (5) @(negedge clk_bus);
    rst_n = 1'b0;
    @(negedge clk_bus);
    check({en_o, clksel_o, chan_o, done_o, sample_o} == 5'b0 && result_o == 8'h00,
          "R1", {en_o, clksel_o, chan_o, done_o, sample_o, result_o}, 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk_bus);
    check(done_o == 1'b0 && result_o == 8'h00, "R1", {done_o, result_o}, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule